// File: doc/BRIEF.md
# Trace Capture Packetizer

This block gathers bytes observed on a smart-card I/O line into fixed-size packets for a host link. Every packet carries a four-byte header in front of its payload: a message type, a set of flag bits and two reserved bytes. A packet is released when its payload area is full. It is also released when the character waiting timer expires, which marks the end of a command/response exchange.

Next to the packet path, the block follows the coarse phase of the card session: card in reset, waiting for the answer-to-reset, inside the answer-to-reset, waiting for a command, and inside a command. Leaving card reset sets a flag in the header of the packet under construction. A timer expiry sets a second flag. A payload buffer is claimed only when the host side signals that one is free. Bytes that arrive while no buffer is open and none is free are dropped and counted in a saturating counter.

Top module: `trace_packetizer`

## Requirements
- R1: After rst_ni is asserted, state_o reads 0 (card reset), pkt_valid_o and buf_take_o are low, and lost_cnt_o is 0.
- R2: Phase codes on state_o are 0 card reset, 1 wait answer-to-reset, 2 in answer-to-reset, 3 wait command, 4 in command. card_rst_i high forces 0 on the next edge and has priority over every other input. From 0 with card_rst_i low the phase goes to 1. A byte in phase 1 moves it to 2. atr_done_i in phase 2 moves it to 3. A byte in phase 3 or 4 moves it to 4.
- R3: wtime_exp_i outside phase 0, with card_rst_i low, moves the phase to 3 on the next edge. It takes precedence over byte and atr_done_i.
- R4: A byte that arrives with no open buffer while buf_free_i is high opens a buffer and pulses buf_take_o one cycle later. An emitted header holds the message type 0x01 in bits 7:0, the flags in bits 15:8 and zero in bits 31:16.
- R5: Payload bytes are kept in arrival order, with the k-th byte of a packet at pkt_data_o[8k+7:8k].
- R6: The cycle after the PAYLOAD_BYTES-th byte of a packet is accepted, pkt_valid_o pulses for one cycle with pkt_len_o equal to PAYLOAD_BYTES.
- R7: On wtime_exp_i, an open packet is emitted on the next cycle with flag bit 1 (bit 9 of the header) set and pkt_len_o equal to its byte count. This includes a byte accepted in the same cycle. With no open packet, nothing is emitted.
- R8: Moving from phase 0 to phase 1 sets flag bit 0 (bit 8 of the header). The flags persist until the next emitted packet carries them, and they are cleared after every emission.
- R9: A byte that arrives with no open buffer while buf_free_i is low is discarded. It opens no packet and appears in no later payload.
- R10: Every discarded byte increments lost_cnt_o by one, and the counter holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Strobe for one received card byte |
| byte_i | input | 8 | Received card byte |
| atr_done_i | input | 1 | Answer-to-reset parsing finished |
| card_rst_i | input | 1 | Card held in reset, active high |
| wtime_exp_i | input | 1 | Waiting-time expiry pulse |
| buf_free_i | input | 1 | Host side has a free payload buffer |
| buf_take_o | output | 1 | A buffer was claimed in the previous cycle |
| pkt_valid_o | output | 1 | Packet present on the packet outputs |
| pkt_hdr_o | output | 32 | Packet header: type, flags, reserved |
| pkt_data_o | output | PAYLOAD_BYTES*8 | Payload, byte 0 in the low bits |
| pkt_len_o | output | $clog2(PAYLOAD_BYTES+1) | Number of valid payload bytes |
| state_o | output | 3 | Session phase code |
| lost_cnt_o | output | LOST_W | Saturating count of dropped bytes |

## Verification
Every result is registered once, so the phase, the buffer-claim pulse, the lost count and the packet all become visible on the edge that samples the causing inputs. They are stable from that edge until the following one. The bench drives inputs on the falling edge and steps its reference model in the same step. On the next falling edge it compares every output against that model, so each check sits exactly one edge after its stimulus. Directed sequences cover the full and short packets, a byte and an expiry arriving together, flags across card reset, and counter saturation. Seeded random traffic then covers the mixed cases.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;
  typedef enum logic [2:0] {
    LS_RESET     = 3'd0,
    LS_WAIT_ATR  = 3'd1,
    LS_IN_ATR    = 3'd2,
    LS_WAIT_APDU = 3'd3,
    LS_IN_APDU   = 3'd4
  } link_state_e;

  localparam logic [7:0] MSG_DATA = 8'h01;
  localparam int FLAG_ATR   = 0;
  localparam int FLAG_WTEXP = 1;

  typedef struct packed {
    logic [15:0] rsvd;
    logic [7:0]  flags;
    logic [7:0]  msg;
  } pkt_hdr_t;
endpackage

// File: rtl/trace_link_fsm.sv
module trace_link_fsm
  import trace_pkt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        card_rst_i,
  input  logic        wtime_exp_i,
  input  logic        byte_valid_i,
  input  logic        atr_done_i,
  output link_state_e state_o,
  output logic        atr_start_o
);
  link_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (card_rst_i)                state_d = LS_RESET;
    else if (state_q == LS_RESET)  state_d = LS_WAIT_ATR;
    else if (wtime_exp_i)          state_d = LS_WAIT_APDU;
    else begin
      unique case (state_q)
        LS_WAIT_ATR:  if (byte_valid_i) state_d = LS_IN_ATR;
        LS_IN_ATR:    if (atr_done_i)   state_d = LS_WAIT_APDU;
        LS_WAIT_APDU,
        LS_IN_APDU:   if (byte_valid_i) state_d = LS_IN_APDU;
        default:      state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_RESET;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign atr_start_o = (state_q == LS_RESET) && !card_rst_i;

  assert_card_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_i |=> state_o == LS_RESET);
  assert_leave_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == LS_RESET && !card_rst_i) |=> state_o == LS_WAIT_ATR);
  assert_wtime_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wtime_exp_i && !card_rst_i && state_o != LS_RESET) |=> state_o == LS_WAIT_APDU);
endmodule

// File: rtl/trace_sat_cnt.sv
module trace_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  assert_hold_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o == '1) |=> cnt_o == '1);
  assert_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o != '1) |=> cnt_o == $past(cnt_o) + W'(1));
endmodule

// File: rtl/trace_pkt_buf.sv
module trace_pkt_buf
  import trace_pkt_pkg::*;
#(
  parameter  int PAYLOAD_BYTES = 8,
  localparam int CNT_W         = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  input  logic                       wtime_exp_i,
  input  logic                       atr_start_i,
  input  logic                       buf_free_i,
  output logic                       drop_o,
  output logic                       buf_take_o,
  output logic                       pkt_valid_o,
  output pkt_hdr_t                   pkt_hdr_o,
  output logic [PAYLOAD_BYTES*8-1:0] pkt_data_o,
  output logic [CNT_W-1:0]           pkt_len_o
);
  logic             open_q, take_q, valid_q;
  logic [CNT_W-1:0] cnt_q, len_q, wr_idx, cnt_now;
  logic [7:0]       flags_q, msg_q, flags_set;
  logic             take, wr, open_now, emit;
  pkt_hdr_t         hdr_q, hdr_now;
  logic [7:0]       pay_q   [PAYLOAD_BYTES];
  logic [7:0]       pay_now [PAYLOAD_BYTES];
  logic [PAYLOAD_BYTES*8-1:0] pay_flat, data_q;

  always_comb begin
    take      = byte_valid_i && !open_q && buf_free_i;
    drop_o    = byte_valid_i && !open_q && !buf_free_i;
    wr        = byte_valid_i && (open_q || buf_free_i);
    wr_idx    = open_q ? cnt_q : '0;
    open_now  = open_q || take;
    cnt_now   = wr ? wr_idx + CNT_W'(1) : cnt_q;
    emit      = open_now && ((cnt_now == CNT_W'(PAYLOAD_BYTES)) || wtime_exp_i);
    flags_set = '0;
    flags_set[FLAG_ATR] = atr_start_i;
    hdr_now.rsvd  = '0;
    hdr_now.msg   = take ? MSG_DATA : msg_q;
    hdr_now.flags = flags_q;
    hdr_now.flags[FLAG_WTEXP] = flags_q[FLAG_WTEXP] | wtime_exp_i;
  end

  for (genvar i = 0; i < PAYLOAD_BYTES; i++) begin : g_slot
    assign pay_now[i] = (wr && wr_idx == CNT_W'(i)) ? byte_i : pay_q[i];
    assign pay_flat[8*i +: 8] = pay_now[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pay_q[i] <= '0;
      else         pay_q[i] <= pay_now[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      cnt_q   <= '0;
      msg_q   <= '0;
      flags_q <= '0;
      take_q  <= 1'b0;
      valid_q <= 1'b0;
      hdr_q   <= '0;
      data_q  <= '0;
      len_q   <= '0;
    end else begin
      take_q  <= take;
      valid_q <= emit;
      if (emit) begin
        open_q  <= 1'b0;
        cnt_q   <= '0;
        msg_q   <= '0;
        flags_q <= flags_set;
        hdr_q   <= hdr_now;
        data_q  <= pay_flat;
        len_q   <= cnt_now;
      end else begin
        open_q  <= open_now;
        cnt_q   <= cnt_now;
        flags_q <= flags_q | flags_set;
        if (take) msg_q <= MSG_DATA;
      end
    end
  end

  assign buf_take_o  = take_q;
  assign pkt_valid_o = valid_q;
  assign pkt_hdr_o   = hdr_q;
  assign pkt_data_o  = data_q;
  assign pkt_len_o   = len_q;

  assert_hdr_type_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_hdr_o.msg == MSG_DATA && pkt_hdr_o.rsvd == '0));
  assert_len_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_len_o != '0 && pkt_len_o <= CNT_W'(PAYLOAD_BYTES)));
  assert_short_is_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_len_o != CNT_W'(PAYLOAD_BYTES)) |-> pkt_hdr_o.flags[FLAG_WTEXP]);
  assert_drop_no_pkt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !open_q && !buf_free_i && !wtime_exp_i) |=> !pkt_valid_o);
endmodule

// File: rtl/trace_packetizer.sv
module trace_packetizer
  import trace_pkt_pkg::*;
#(
  parameter  int PAYLOAD_BYTES = 8,
  parameter  int LOST_W        = 8,
  localparam int CNT_W         = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  input  logic                       atr_done_i,
  input  logic                       card_rst_i,
  input  logic                       wtime_exp_i,
  input  logic                       buf_free_i,
  output logic                       buf_take_o,
  output logic                       pkt_valid_o,
  output logic [31:0]                pkt_hdr_o,
  output logic [PAYLOAD_BYTES*8-1:0] pkt_data_o,
  output logic [CNT_W-1:0]           pkt_len_o,
  output logic [2:0]                 state_o,
  output logic [LOST_W-1:0]          lost_cnt_o
);
  link_state_e link_state;
  logic        atr_start, drop;
  pkt_hdr_t    hdr;

  trace_link_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .card_rst_i   (card_rst_i),
    .wtime_exp_i  (wtime_exp_i),
    .byte_valid_i (byte_valid_i),
    .atr_done_i   (atr_done_i),
    .state_o      (link_state),
    .atr_start_o  (atr_start)
  );

  trace_pkt_buf #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .wtime_exp_i  (wtime_exp_i),
    .atr_start_i  (atr_start),
    .buf_free_i   (buf_free_i),
    .drop_o       (drop),
    .buf_take_o   (buf_take_o),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_hdr_o    (hdr),
    .pkt_data_o   (pkt_data_o),
    .pkt_len_o    (pkt_len_o)
  );

  trace_sat_cnt #(.W(LOST_W)) u_lost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop),
    .cnt_o  (lost_cnt_o)
  );

  assign pkt_hdr_o = hdr;
  assign state_o   = link_state;
endmodule

// File: tb/trace_packetizer_test.sv
module trace_packetizer_test;
  localparam int PAY = 8;
  localparam int LW  = 8;
  localparam int CW  = $clog2(PAY + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0, ad = 1'b0, cr = 1'b1, wt = 1'b0, bf = 1'b0;
  logic [7:0] bdat = '0;
  logic take_o, valid_o;
  logic [31:0] hdr_o;
  logic [PAY*8-1:0] data_o;
  logic [CW-1:0] len_o;
  logic [2:0] state_o;
  logic [LW-1:0] lost_o;

  always #2 clk = ~clk;

  trace_packetizer #(.PAYLOAD_BYTES(PAY), .LOST_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bdat),
    .atr_done_i(ad), .card_rst_i(cr), .wtime_exp_i(wt), .buf_free_i(bf),
    .buf_take_o(take_o), .pkt_valid_o(valid_o), .pkt_hdr_o(hdr_o),
    .pkt_data_o(data_o), .pkt_len_o(len_o), .state_o(state_o),
    .lost_cnt_o(lost_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  int         m_state = 0;
  bit         m_open = 0;
  int         m_cnt = 0;
  logic [7:0] m_pay [PAY];
  logic [7:0] m_flags = 0, m_type = 0;
  int         m_lost = 0;
  bit         e_valid = 0, e_take = 0;
  int         e_len = 0;
  logic [31:0] e_hdr = 0;
  logic [7:0] e_pay [PAY];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int next_state(int s, bit b, bit a, bit c, bit w);
    if (c) return 0;
    if (s == 0) return 1;
    if (w) return 3;
    if (s == 1 && b) return 2;
    if (s == 2 && a) return 3;
    if ((s == 3 || s == 4) && b) return 4;
    return s;
  endfunction

  task automatic model_step(input bit b, input logic [7:0] d, input bit a,
                            input bit c, input bit w, input bit f);
    bit atr_set = (m_state == 0) && !c;
    e_valid = 0;
    e_take  = 0;
    if (b) begin
      if (!m_open) begin
        if (f) begin
          m_open = 1; m_cnt = 0; m_type = 8'h01; e_take = 1;
        end else if (m_lost < (1 << LW) - 1) m_lost++;
      end
      if (m_open) begin
        m_pay[m_cnt] = d;
        m_cnt++;
      end
    end
    if (m_open && (m_cnt == PAY || w)) begin
      e_valid = 1;
      e_len   = m_cnt;
      e_hdr   = {16'h0, m_flags | (w ? 8'h02 : 8'h00), m_type};
      for (int i = 0; i < PAY; i++) e_pay[i] = m_pay[i];
      m_flags = 0; m_type = 0; m_open = 0; m_cnt = 0;
    end
    if (atr_set) m_flags = m_flags | 8'h01;
    m_state = next_state(m_state, b, a, c, w);
  endtask

  task automatic compare();
    chk("R2_R3 state", 64'(state_o), 64'(m_state));
    chk("R6_R7 valid", 64'(valid_o), 64'(e_valid));
    chk("R4 take", 64'(take_o), 64'(e_take));
    chk("R9_R10 lost", 64'(lost_o), 64'(m_lost));
    if (e_valid && valid_o) begin
      chk("R4 type", 64'(hdr_o[7:0]), 64'(e_hdr[7:0]));
      chk("R7_R8 flags", 64'(hdr_o[15:8]), 64'(e_hdr[15:8]));
      chk("R4 reserved", 64'(hdr_o[31:16]), 64'h0);
      chk("R6_R7 len", 64'(len_o), 64'(e_len));
      for (int i = 0; i < e_len; i++)
        chk("R5 payload", 64'(data_o[8*i +: 8]), 64'(e_pay[i]));
    end
  endtask

  task automatic cyc(input bit b, input logic [7:0] d, input bit a,
                     input bit c, input bit w, input bit f);
    @(negedge clk);
    compare();
    bv = b; bdat = d; ad = a; cr = c; wt = w; bf = f;
    model_step(b, d, a, c, w, f);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20517));
    for (int i = 0; i < PAY; i++) begin m_pay[i] = 0; e_pay[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", 64'(state_o), 64'h0);
    chk("R1 valid", 64'(valid_o), 64'h0);
    chk("R1 take", 64'(take_o), 64'h0);
    chk("R1 lost", 64'(lost_o), 64'h0);
    rst_n = 1'b1;
    // card held in reset
    repeat (3) cyc(0, 0, 0, 1, 0, 1);
    // leave reset: R2 phase 1, R8 flag
    repeat (2) cyc(0, 0, 0, 0, 0, 1);
    // answer-to-reset bytes open a buffer (R4), phase 2
    for (int i = 0; i < 5; i++) cyc(1, 8'h3b + 8'(i), 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 1);
    // expiry: short packet with both flags (R7, R8)
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1);
    // full packet (R6, R5)
    for (int i = 0; i < PAY; i++) cyc(1, 8'ha0 + 8'(i), 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    // expiry with no open packet: nothing (R7)
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1);
    // byte and expiry together, and a filling byte with expiry (R7)
    for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 1);
    cyc(1, 8'h55, 0, 0, 1, 1);
    for (int i = 0; i < PAY - 1; i++) cyc(1, 8'h20 + 8'(i), 0, 0, 0, 1);
    cyc(1, 8'h66, 0, 0, 1, 1);
    // drops until saturation (R9, R10)
    for (int i = 0; i < 300; i++) cyc(1, 8'(i), 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    // seeded random mix
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 2) == 0, 8'($urandom), ($urandom % 10) == 0,
          ($urandom % 100) == 0, ($urandom % 20) == 0, ($urandom % 5) != 0);
    end
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    finish_run();
  end
endmodule